// File: doc/BRIEF.md
# Bus Handoff and Search Resume Controller

This controller sits beside a table-search engine that walks translation tables over a shared bus. While a search is running, another bus master may ask for the bus. The controller keeps the search going until the grant-in line says the other master has been granted. It then raises grant-out and waits for the bus cycle in progress to finish. It floats the shared control lines, and only after that does it drop its own grant acknowledge. The point the search had reached is saved.

How the search continues depends on what started it. A search started by a cache miss is parked, and the controller waits for the logical master to retry the access that missed. A search started by an explicit test or load command asks for the bus back at once. In both cases the controller regains the bus with a new request, a grant and an acknowledge. It then tells the engine either to resume from the saved point or to restart from the beginning. It restarts when any internal operation happened while the search was set aside, or when the retried access does not match the parked one. Searches that finish normally release the bus through the same float-then-unacknowledge order and return to idle.

Top module: `search_handoff_ctrl`

## Requirements
- R1: After synchronous reset, grant-out, grant acknowledge, line drive enable, bus request and all three engine commands are low.
- R2: Grant-out rises only on the cycle after grant-in was sampled high during a search, and stays low while grant-in stays low.
- R3: After grant-out rises, the shared lines keep being driven until cycle-done is sampled; drive enable falls only on the cycle after cycle-done or search-done.
- R4: Drive enable falls one cycle before grant acknowledge falls, and drive enable is never high while acknowledge is low.
- R5: A parked search begun by a miss (start_miss_i) holds cmd_wait_o high and bus_req_o low until a retry arrives.
- R6: A miss-started search whose retry matches the parked logical address and function code, with no internal operation since the interruption, gets a one-cycle cmd_resume_o.
- R7: One or more internal_op_i pulses while the search is parked or re-requesting the bus force a one-cycle cmd_restart_o instead of a resume.
- R8: A search begun by a command (start_cmd_i) requests the bus again right after release, with no retry, and ignores retry_i.
- R9: A retry whose address or function code differs from the parked one discards the saved point; the search is started afresh with cmd_restart_o.
- R10: A resume or restart command is issued only with grant acknowledge high and on the cycle after own_grant_i was sampled during an active bus request.
- R11: At most one of cmd_resume_o, cmd_restart_o and cmd_wait_o is high in any cycle.
- R12: A search that completes (search_done_i) floats the lines, drops acknowledge and returns to idle with no wait and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_miss_i | input | 1 | Pulse: begin a search caused by a cache miss (idle only) |
| start_cmd_i | input | 1 | Pulse: begin a search caused by a test/load command (idle only) |
| req_addr_i | input | ADDR_W | Logical address of the start or retry request |
| req_fc_i | input | FC_W | Function code of the start or retry request |
| retry_i | input | 1 | Pulse: the logical master retries a cycle |
| internal_op_i | input | 1 | Pulse: some other internal operation took place |
| grant_in_i | input | 1 | Another master has been granted the bus |
| cycle_done_i | input | 1 | The engine's current bus cycle completes this cycle |
| search_done_i | input | 1 | The search completes with this cycle |
| own_grant_i | input | 1 | Arbiter grants the bus back to this controller |
| grant_out_o | output | 1 | Bus will be released at the end of the current cycle |
| grant_ack_o | output | 1 | This controller holds the bus |
| drive_en_o | output | 1 | Enable for the shared control line drivers |
| bus_req_o | output | 1 | Request to regain the bus |
| cmd_resume_o | output | 1 | Pulse: engine continues from the saved point |
| cmd_restart_o | output | 1 | Pulse: engine starts the search from its first level |
| cmd_wait_o | output | 1 | Engine holds, waiting for the retry |

## Verification
The assertions take for granted that own_grant_i is pulsed only while bus_req_o is high, and that cycle_done_i and search_done_i come only while the engine owns the bus. They also assume that search_done_i marks the end of a completed bus cycle. The bench drives every input on the falling edge as a single-cycle pulse. It raises each of these inputs only in the phase where a real engine or arbiter could. The one exception is retry_i, which it also sends while a command-started search re-requests the bus, to show that it is ignored. The sweep covers both origins, with and without an intervening internal operation, against a matching retry, an address mismatch and a function-code mismatch.

// File: rtl/hoff_pkg.sv
package hoff_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_ACQ   = 3'd2,
    ST_RUN   = 3'd3,
    ST_YIELD = 3'd4,
    ST_FLOAT = 3'd5,
    ST_PARK  = 3'd6
  } hoff_state_e;

  typedef enum logic {
    ORG_MISS = 1'b0,
    ORG_CMD  = 1'b1
  } hoff_origin_e;

endpackage

// File: rtl/hoff_ctx.sv
module hoff_ctx
  import hoff_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 4,
  parameter bit CMP_FC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  hoff_state_e       state_i,
  input  logic              start_miss_i,
  input  logic              start_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [FC_W-1:0]   req_fc_i,
  input  logic              retry_i,
  input  logic              internal_op_i,
  input  logic              cycle_done_i,
  input  logic              search_done_i,
  output hoff_origin_e      origin_o,
  output logic              resume_sel_o
);

  localparam int TAG_W = ADDR_W + FC_W;

  logic [ADDR_W-1:0] tag_addr_r;
  logic [FC_W-1:0]   tag_fc_r;
  hoff_origin_e      origin_r;
  logic              resumable_r;
  logic              dirty_r;
  logic              tag_match;
  logic              holding;
  logic              starting;
  logic              saving;
  logic              retry_miss;

  generate
    if (CMP_FC) begin : g_cmp_full
      logic [TAG_W-1:0] tag_now;
      logic [TAG_W-1:0] tag_req;
      assign tag_now   = {tag_addr_r, tag_fc_r};
      assign tag_req   = {req_addr_i, req_fc_i};
      assign tag_match = (tag_now == tag_req);
    end else begin : g_cmp_addr
      assign tag_match = (tag_addr_r == req_addr_i);
    end
  endgenerate

  assign holding    = (state_i == ST_PARK) || (state_i == ST_REQ);
  assign starting   = (state_i == ST_IDLE) && (start_miss_i || start_cmd_i);
  assign saving     = (state_i == ST_YIELD) && cycle_done_i;
  assign retry_miss = (state_i == ST_PARK) && (origin_r == ORG_MISS) && retry_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_addr_r  <= '0;
      tag_fc_r    <= '0;
      origin_r    <= ORG_MISS;
      resumable_r <= 1'b0;
      dirty_r     <= 1'b0;
    end else begin
      if (starting) begin
        origin_r    <= start_miss_i ? ORG_MISS : ORG_CMD;
        tag_addr_r  <= req_addr_i;
        tag_fc_r    <= req_fc_i;
        resumable_r <= 1'b0;
        dirty_r     <= 1'b0;
      end
      if (saving) begin
        resumable_r <= !search_done_i;
        dirty_r     <= 1'b0;
      end
      if ((state_i == ST_RUN) && search_done_i) begin
        resumable_r <= 1'b0;
      end
      if (retry_miss && !tag_match) begin
        tag_addr_r  <= req_addr_i;
        tag_fc_r    <= req_fc_i;
        resumable_r <= 1'b0;
      end
      if (holding && internal_op_i) begin
        dirty_r <= 1'b1;
      end
      if (state_i == ST_ACQ) begin
        dirty_r <= 1'b0;
      end
    end
  end

  assign origin_o     = origin_r;
  assign resume_sel_o = resumable_r && !dirty_r && !(holding && internal_op_i);

  // R9: a mismatching retry leaves nothing to resume
  a_r9_mismatch_drops_point: assert property (@(posedge clk) disable iff (rst)
    (retry_miss && !tag_match) |=> !resume_sel_o);

endmodule

// File: rtl/hoff_seq.sv
module hoff_seq
  import hoff_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start_miss_i,
  input  logic         start_cmd_i,
  input  logic         retry_i,
  input  logic         grant_in_i,
  input  logic         cycle_done_i,
  input  logic         search_done_i,
  input  logic         own_grant_i,
  input  hoff_origin_e origin_i,
  input  logic         resume_sel_i,
  output hoff_state_e  state_o,
  output logic         grant_out_o,
  output logic         grant_ack_o,
  output logic         drive_en_o,
  output logic         bus_req_o,
  output logic         cmd_resume_o,
  output logic         cmd_restart_o,
  output logic         cmd_wait_o
);

  hoff_state_e state_r, state_n;
  logic        fin_r, fin_n;

  always_comb begin
    state_n = state_r;
    fin_n   = fin_r;
    unique case (state_r)
      ST_IDLE: begin
        fin_n = 1'b0;
        if (start_miss_i || start_cmd_i) state_n = ST_REQ;
      end
      ST_REQ: begin
        if (own_grant_i) state_n = ST_ACQ;
      end
      ST_ACQ: begin
        fin_n   = 1'b0;
        state_n = ST_RUN;
      end
      ST_RUN: begin
        if (search_done_i) begin
          fin_n   = 1'b1;
          state_n = ST_FLOAT;
        end else if (grant_in_i) begin
          state_n = ST_YIELD;
        end
      end
      ST_YIELD: begin
        if (cycle_done_i) begin
          fin_n   = search_done_i;
          state_n = ST_FLOAT;
        end
      end
      ST_FLOAT: begin
        state_n = fin_r ? ST_IDLE : ST_PARK;
      end
      ST_PARK: begin
        if (origin_i == ORG_CMD)  state_n = ST_REQ;
        else if (retry_i)         state_n = ST_REQ;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r       <= ST_IDLE;
      fin_r         <= 1'b0;
      grant_out_o   <= 1'b0;
      grant_ack_o   <= 1'b0;
      drive_en_o    <= 1'b0;
      bus_req_o     <= 1'b0;
      cmd_resume_o  <= 1'b0;
      cmd_restart_o <= 1'b0;
      cmd_wait_o    <= 1'b0;
    end else begin
      state_r       <= state_n;
      fin_r         <= fin_n;
      grant_out_o   <= (state_n == ST_YIELD) || (state_n == ST_FLOAT && !fin_n);
      grant_ack_o   <= (state_n == ST_ACQ) || (state_n == ST_RUN) ||
                       (state_n == ST_YIELD) || (state_n == ST_FLOAT);
      drive_en_o    <= (state_n == ST_ACQ) || (state_n == ST_RUN) ||
                       (state_n == ST_YIELD);
      bus_req_o     <= (state_n == ST_REQ);
      cmd_resume_o  <= (state_n == ST_ACQ) && resume_sel_i;
      cmd_restart_o <= (state_n == ST_ACQ) && !resume_sel_i;
      cmd_wait_o    <= (state_n == ST_PARK) && (origin_i == ORG_MISS);
    end
  end

  assign state_o = state_r;

  // R2: grant-out only follows a sampled grant-in
  a_r2_gout_after_gin: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_out_o) |-> $past(grant_in_i));

  // R3: lines float only once a bus cycle has ended
  a_r3_release_at_cycle_end: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_en_o) |-> $past(cycle_done_i || search_done_i));

  // R4: float first, then drop acknowledge
  a_r4_float_before_unack: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_ack_o) |-> $past(!drive_en_o));

  a_r4_drive_needs_ack: assert property (@(posedge clk) disable iff (rst)
    drive_en_o |-> grant_ack_o);

  // R5: waiting for a retry never requests the bus
  a_r5_wait_no_request: assert property (@(posedge clk) disable iff (rst)
    cmd_wait_o |-> !bus_req_o);

  // R10: commands only after a fresh request, grant and acknowledge
  a_r10_cmd_after_regain: assert property (@(posedge clk) disable iff (rst)
    (cmd_resume_o || cmd_restart_o) |-> (grant_ack_o && $past(own_grant_i) && $past(bus_req_o)));

  // R11: commands are mutually exclusive
  a_r11_one_command: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_resume_o, cmd_restart_o, cmd_wait_o}));

endmodule

// File: rtl/search_handoff_ctrl.sv
module search_handoff_ctrl
  import hoff_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 4,
  parameter bit CMP_FC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_miss_i,
  input  logic              start_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [FC_W-1:0]   req_fc_i,
  input  logic              retry_i,
  input  logic              internal_op_i,
  input  logic              grant_in_i,
  input  logic              cycle_done_i,
  input  logic              search_done_i,
  input  logic              own_grant_i,
  output logic              grant_out_o,
  output logic              grant_ack_o,
  output logic              drive_en_o,
  output logic              bus_req_o,
  output logic              cmd_resume_o,
  output logic              cmd_restart_o,
  output logic              cmd_wait_o
);

  hoff_state_e  state;
  hoff_origin_e origin;
  logic         resume_sel;

  hoff_ctx #(
    .ADDR_W (ADDR_W),
    .FC_W   (FC_W),
    .CMP_FC (CMP_FC)
  ) u_ctx (
    .clk           (clk),
    .rst           (rst),
    .state_i       (state),
    .start_miss_i  (start_miss_i),
    .start_cmd_i   (start_cmd_i),
    .req_addr_i    (req_addr_i),
    .req_fc_i      (req_fc_i),
    .retry_i       (retry_i),
    .internal_op_i (internal_op_i),
    .cycle_done_i  (cycle_done_i),
    .search_done_i (search_done_i),
    .origin_o      (origin),
    .resume_sel_o  (resume_sel)
  );

  hoff_seq u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_miss_i  (start_miss_i),
    .start_cmd_i   (start_cmd_i),
    .retry_i       (retry_i),
    .grant_in_i    (grant_in_i),
    .cycle_done_i  (cycle_done_i),
    .search_done_i (search_done_i),
    .own_grant_i   (own_grant_i),
    .origin_i      (origin),
    .resume_sel_i  (resume_sel),
    .state_o       (state),
    .grant_out_o   (grant_out_o),
    .grant_ack_o   (grant_ack_o),
    .drive_en_o    (drive_en_o),
    .bus_req_o     (bus_req_o),
    .cmd_resume_o  (cmd_resume_o),
    .cmd_restart_o (cmd_restart_o),
    .cmd_wait_o    (cmd_wait_o)
  );

endmodule

// File: tb/search_handoff_ctrl_test.sv
module search_handoff_ctrl_test;

  localparam int AW = 24;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_miss = 1'b0, start_cmd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [FW-1:0] fc = '0;
  logic          retry = 1'b0, iop = 1'b0, gin = 1'b0;
  logic          cdone = 1'b0, sdone = 1'b0, ogrant = 1'b0;
  logic          gout, gack, drv, breq, c_res, c_rst, c_wait;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  search_handoff_ctrl #(.ADDR_W(AW), .FC_W(FW), .CMP_FC(1'b1)) uut (
    .clk(clk), .rst(rst), .start_miss_i(start_miss), .start_cmd_i(start_cmd),
    .req_addr_i(addr), .req_fc_i(fc), .retry_i(retry), .internal_op_i(iop),
    .grant_in_i(gin), .cycle_done_i(cdone), .search_done_i(sdone),
    .own_grant_i(ogrant), .grant_out_o(gout), .grant_ack_o(gack),
    .drive_en_o(drv), .bus_req_o(breq), .cmd_resume_o(c_res),
    .cmd_restart_o(c_rst), .cmd_wait_o(c_wait)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic scenario(input bit is_cmd, input bit with_op, input int rkind);
    logic [AW-1:0] a0;
    logic [FW-1:0] f0;
    bit exp_res;
    string tag;
    a0 = AW'(24'h3A5000 + (rkind * 16) + (with_op * 4) + is_cmd);
    f0 = FW'(4'h5 + rkind);
    exp_res = !with_op && (is_cmd || (rkind == 0));
    if (is_cmd) tag = with_op ? "R8/R7 cmd restart" : "R8 cmd resume";
    else if (with_op) tag = "R7 op forces restart";
    else if (rkind != 0) tag = "R9 mismatch restart";
    else tag = "R6 match resume";

    chk(gack, 1'b0, "R12 idle ack low");
    addr = a0; fc = f0;
    if (is_cmd) start_cmd = 1'b1; else start_miss = 1'b1;
    step();
    start_cmd = 1'b0; start_miss = 1'b0;
    chk(breq, 1'b1, "R10 start requests bus");
    chk(gack, 1'b0, "R10 no ack before grant");
    ogrant = 1'b1; step(); ogrant = 1'b0;
    chk(gack, 1'b1, "R10 ack after grant");
    chk(c_rst, 1'b1, "R10 fresh search restart");
    chk(c_res, 1'b0, "R11 no resume on fresh");
    step(); step();
    chk(gout, 1'b0, "R2 no grant-out without grant-in");
    gin = 1'b1; step(); gin = 1'b0;
    chk(gout, 1'b1, "R2 grant-out after grant-in");
    chk(drv, 1'b1, "R3 still driving mid cycle");
    step();
    chk(drv, 1'b1, "R3 waits for cycle end");
    cdone = 1'b1; step(); cdone = 1'b0;
    chk(drv, 1'b0, "R4 lines floated");
    chk(gack, 1'b1, "R4 ack held while floated");
    step();
    chk(gack, 1'b0, "R4 ack dropped after float");
    chk(gout, 1'b0, "R4 grant-out cleared");
    iop = with_op; step(); iop = 1'b0;
    if (!is_cmd) begin
      chk(c_wait, 1'b1, "R5 wait held");
      chk(breq, 1'b0, "R5 no request before retry");
      step();
      chk(c_wait, 1'b1, "R5 still waiting");
      addr = (rkind == 1) ? (a0 ^ AW'(1)) : a0;
      fc   = (rkind == 2) ? (f0 ^ FW'(1)) : f0;
      retry = 1'b1; step(); retry = 1'b0;
      chk(breq, 1'b1, "R5 request after retry");
      chk(c_wait, 1'b0, "R11 wait dropped");
    end else begin
      chk(breq, 1'b1, "R8 request without retry");
      chk(c_wait, 1'b0, "R8 no wait");
      addr = a0 ^ AW'(rkind); retry = 1'b1; step(); retry = 1'b0;
      chk(breq, 1'b1, "R8 retry ignored");
    end
    ogrant = 1'b1; step(); ogrant = 1'b0;
    chk(gack, 1'b1, "R10 ack on regain");
    chk(c_res, exp_res, tag);
    chk(c_rst, !exp_res, tag);
    step();
    chk(c_res | c_rst, 1'b0, "R11 command is one pulse");
    sdone = 1'b1; cdone = 1'b1; step(); sdone = 1'b0; cdone = 1'b0;
    chk(drv, 1'b0, "R12 done floats lines");
    chk(gack, 1'b1, "R12 ack held one cycle");
    step();
    chk(gack, 1'b0, "R12 ack dropped");
    chk(c_wait, 1'b0, "R12 no wait after done");
    chk(breq, 1'b0, "R12 no request after done");
    step();
  endtask

  initial begin
    step(); step();
    chk(gack | gout | drv | breq, 1'b0, "R1 bus outputs quiet in reset");
    chk(c_res | c_rst | c_wait, 1'b0, "R1 commands quiet in reset");
    rst = 1'b0;
    step();
    chk(gack, 1'b0, "R1 idle after reset");
    for (int o = 0; o < 2; o++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 3; k++)
          scenario(o[0], p[0], k);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 50000);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule